// File: doc/BRIEF.md
# Unanimous-Vote Input Glitch Filter

This block conditions one slow or noisy asynchronous input, such as an I2C clock or data line with a rise time of a few hundred nanoseconds, before synchronous logic consumes it. The raw level is shifted through a chain of `STAGES` flip-flops. A set/reset element watches every tap of the chain. It drives the cleaned output high only when all taps read high, drives it low only when all taps read low, and otherwise keeps its current value. That held value is the block's output register.

Because a change needs a unanimous chain, any excursion shorter than `STAGES` clock cycles is absorbed, and a clean change reaches the output a fixed number of cycles later. The filter has hysteresis, unlike a plain two-flop synchronizer or a majority voter. Optional one-cycle pulses flag each rising and falling transition of the cleaned output. On synchronous reset every register loads a chosen idle level, so reset release produces no spurious edge. `STAGES` is legal from 3 to 8. Values outside that range are clamped.

Top module: `unanimous_glitch_filter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following cycle shows `dout_clean` equal to `IDLE_LEVEL` with `rise_pulse` and `fall_pulse` low. Releasing reset with the input at the idle level produces no pulse.
- R2: After the input has been low and then is held high, `dout_clean` goes high at exactly the (STAGES+1)-th rising edge after the change.
- R3: After the input has been high and then is held low, `dout_clean` goes low at exactly the (STAGES+1)-th rising edge after the change.
- R4: An input excursion of either polarity that lasts fewer than `STAGES` clock cycles never changes `dout_clean`.
- R5: An excursion lasting exactly `STAGES` cycles does pass. The output changes and returns, staying at the excursion level for `STAGES` cycles.
- R6: `dout_clean` changes only after the input has shown the new level on `STAGES` consecutive rising edges. While the samples disagree (for example, a toggling input), it holds its value.
- R7: `rise_pulse` is high for exactly the one cycle in which `dout_clean` has just changed from 0 to 1. It is never high together with `fall_pulse`.
- R8: `fall_pulse` is high for exactly the one cycle in which `dout_clean` has just changed from 1 to 0.
- R9: With `IDLE_LEVEL` = 0, reset drives `dout_clean` low. The output stays low on the first cycle after release even if the input is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low; loads the idle level everywhere |
| din_raw | input | 1 | Raw asynchronous input level |
| dout_clean | output | 1 | Filtered, registered level |
| rise_pulse | output | 1 | One-cycle pulse when `dout_clean` has just risen |
| fall_pulse | output | 1 | One-cycle pulse when `dout_clean` has just fallen |

## Verification
An input level that is set just after a falling edge and then held is due on `dout_clean` after the (STAGES+1)-th following rising edge. The matching edge pulse appears in that same cycle, and a reset edge is seen one cycle later. The bench's driver steps a reference chain once per driven cycle and queues the outputs expected after the coming rising edge. The monitor compares each queued item at the next falling edge, so every result is sampled exactly one edge after the stimulus that caused it. Glitch widths 1 to STAGES-1, a width of exactly STAGES, toggling input and a reset applied mid-run are each tagged with their requirement.

// File: rtl/glitch_filter_pkg.sv
// Package: shared types and limits for the unanimous-vote glitch filter.
// Assumes: consumers import it; nothing here holds state.
package glitch_filter_pkg;
    localparam int MIN_STAGES = 3;
    localparam int MAX_STAGES = 8;

    // Verdict of the chain taps on one cycle.
    typedef enum logic [1:0] {
        VOTE_SPLIT    = 2'b00,
        VOTE_ALL_LOW  = 2'b01,
        VOTE_ALL_HIGH = 2'b10
    } vote_e;
endpackage

// File: rtl/ugf_sample_chain.sv
// Module: shift chain sampling the raw input once per clock.
// Assumes: din is asynchronous. Tap 0 takes din straight in and tap 1 takes
// tap 0 straight in, so only the flop's own synchronous reset sits before them.
module ugf_sample_chain #(
    parameter int   LEN        = 4,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           din,
    output logic [LEN-1:0] taps
);
    // Shift the newest sample into tap 0; reset loads the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) taps <= {LEN{IDLE_LEVEL}};
        else        taps <= {taps[LEN-2:0], din};
    end
endmodule

// File: rtl/ugf_vote_decode.sv
// Module: unanimous decision over all chain taps.
// Assumes: taps are registered; the output is purely combinational.
module ugf_vote_decode
    import glitch_filter_pkg::*;
#(
    parameter int LEN = 4
) (
    input  logic [LEN-1:0] taps,
    output vote_e          vote
);
    // Report a verdict only when every tap agrees.
    always_comb begin
        if (&taps)       vote = VOTE_ALL_HIGH;
        else if (~|taps) vote = VOTE_ALL_LOW;
        else             vote = VOTE_SPLIT;
    end
endmodule

// File: rtl/ugf_hold_reg.sv
// Module: set/reset output register driven by the vote.
// Assumes: vote comes from registered taps, so q is glitch-free.
module ugf_hold_reg
    import glitch_filter_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  vote_e vote,
    output logic  q
);
    // Set on all-high, clear on all-low, keep the level on a split.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= IDLE_LEVEL;
        end else begin
            case (vote)
                VOTE_ALL_HIGH: q <= 1'b1;
                VOTE_ALL_LOW:  q <= 1'b0;
                default:       q <= q;
            endcase
        end
    end
endmodule

// File: rtl/ugf_edge_detect.sv
// Module: one-cycle rise/fall markers for the filtered level.
// Assumes: level is registered; prev is reset to the same idle level.
module ugf_edge_detect #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic prev;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE_LEVEL;
        else        prev <= level;
    end

    // Compare current and previous level.
    always_comb begin
        rise = level & ~prev;
        fall = ~level & prev;
    end
endmodule

// File: rtl/unanimous_glitch_filter.sv
// Module: top of the unanimous-vote input glitch filter.
// Assumes: one clock, synchronous active-low reset. STAGES is clamped to
// the package limits. Latency from a clean input change is CHAIN_LEN+1 edges.
module unanimous_glitch_filter
    import glitch_filter_pkg::*;
#(
    parameter int   STAGES      = 4,
    parameter logic IDLE_LEVEL  = 1'b1,
    parameter bit   EDGE_OUT_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_raw,
    output logic dout_clean,
    output logic rise_pulse,
    output logic fall_pulse
);
    localparam int CHAIN_LEN = (STAGES < MIN_STAGES) ? MIN_STAGES :
                               (STAGES > MAX_STAGES) ? MAX_STAGES : STAGES;

    logic [CHAIN_LEN-1:0] taps;
    vote_e                vote;
    logic                 held;

    ugf_sample_chain #(.LEN(CHAIN_LEN), .IDLE_LEVEL(IDLE_LEVEL)) u_chain (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (din_raw),
        .taps (taps)
    );

    ugf_vote_decode #(.LEN(CHAIN_LEN)) u_vote (
        .taps(taps),
        .vote(vote)
    );

    ugf_hold_reg #(.IDLE_LEVEL(IDLE_LEVEL)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .vote (vote),
        .q    (held)
    );

    assign dout_clean = held;

    // Edge markers are built only when requested.
    generate
        if (EDGE_OUT_EN) begin : g_edges
            ugf_edge_detect #(.IDLE_LEVEL(IDLE_LEVEL)) u_edge (
                .clk  (clk),
                .rst_n(rst_n),
                .level(held),
                .rise (rise_pulse),
                .fall (fall_pulse)
            );
        end else begin : g_no_edges
            assign rise_pulse = 1'b0;
            assign fall_pulse = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/ugf_checker.sv
// Module: property checker bound to every filter instance.
// Assumes: the edge outputs are enabled. It keeps its own run counter of
// identical input samples, so it never reads the filter's internals.
module ugf_checker #(
    parameter int   STAGES     = 4,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic din_raw,
    input logic dout_clean,
    input logic rise_pulse,
    input logic fall_pulse
);
    localparam int CW = $clog2(STAGES + 1);

    logic          run_val;
    logic [CW-1:0] run_cnt;

    // Count consecutive equal input samples, saturating at STAGES.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_val <= IDLE_LEVEL;
            run_cnt <= '0;
        end else if (din_raw == run_val) begin
            if (int'(run_cnt) < STAGES) run_cnt <= run_cnt + 1'b1;
        end else begin
            run_val <= din_raw;
            run_cnt <= CW'(1);
        end
    end

    AST_RESET_LOADS_IDLE: assert property (@(posedge clk)
        !rst_n |=> (dout_clean == IDLE_LEVEL && !rise_pulse && !fall_pulse)); // R1

    AST_SETTLES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(run_cnt) >= STAGES && run_val) |=> dout_clean); // R2

    AST_SETTLES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(run_cnt) >= STAGES && !run_val) |=> !dout_clean); // R3

    AST_CHANGE_NEEDS_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dout_clean != $past(dout_clean))
        |-> ($past(run_val) == dout_clean && int'($past(run_cnt)) >= STAGES)); // R6

    AST_RISE_MARKS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rise_pulse == $rose(dout_clean))); // R7

    AST_FALL_MARKS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fall_pulse == $fell(dout_clean))); // R8

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_pulse, fall_pulse})); // R7
endmodule

bind unanimous_glitch_filter ugf_checker #(
    .STAGES    (CHAIN_LEN),
    .IDLE_LEVEL(IDLE_LEVEL)
) u_ugf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .din_raw   (din_raw),
    .dout_clean(dout_clean),
    .rise_pulse(rise_pulse),
    .fall_pulse(fall_pulse)
);

// File: tb/tb_unanimous_glitch_filter.sv
// Bench: scoreboard. A driver task steps a spec-level reference chain and
// queues the expected outputs; a monitor pops and compares at falling edges.
module tb_unanimous_glitch_filter;
    localparam int   CLK_PERIOD = 10;
    localparam int   N          = 4;
    localparam logic IDLE       = 1'b1;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic din   = 1'b1;
    logic dout, rise, fall;
    logic dout_lo, rise_lo, fall_lo;

    typedef struct {
        logic  out;
        logic  rise;
        logic  fall;
        string tag;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errors = 0;
    logic [N-1:0] m_stg = {N{IDLE}};
    logic       m_out   = IDLE;

    unanimous_glitch_filter #(.STAGES(N), .IDLE_LEVEL(IDLE)) dut (
        .clk(clk), .rst_n(rst_n), .din_raw(din),
        .dout_clean(dout), .rise_pulse(rise), .fall_pulse(fall)
    );

    unanimous_glitch_filter #(.STAGES(3), .IDLE_LEVEL(1'b0)) dut_lo (
        .clk(clk), .rst_n(rst_n), .din_raw(din),
        .dout_clean(dout_lo), .rise_pulse(rise_lo), .fall_pulse(fall_lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Drive one cycle and queue what the outputs must be after the next edge.
    task automatic step(input logic v, input string tag, input bit in_reset);
        exp_t e;
        logic nxt;
        @(negedge clk); #1;
        din   = v;
        rst_n = in_reset ? 1'b0 : 1'b1;
        if (in_reset) begin
            m_stg = {N{IDLE}};
            e.rise = 1'b0; e.fall = 1'b0; e.out = IDLE;
            m_out = IDLE;
        end else begin
            if (&m_stg)       nxt = 1'b1;
            else if (~|m_stg) nxt = 1'b0;
            else              nxt = m_out;
            m_stg  = {m_stg[N-2:0], v};
            e.rise = nxt & ~m_out;
            e.fall = ~nxt & m_out;
            e.out  = nxt;
            m_out  = nxt;
        end
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic hold(input logic v, input int n, input string tag);
        for (int i = 0; i < n; i++) step(v, tag, 1'b0);
    endtask

    task automatic chk(input bit ok, input string tag, input logic got, input logic expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, expv);
        end
    endtask

    // Monitor: compare one queued item per falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (dout !== e.out || rise !== e.rise || fall !== e.fall) begin
                    errors++;
                    $display("FAIL %s: out/rise/fall got %b%b%b expected %b%b%b",
                             e.tag, dout, rise, fall, e.out, e.rise, e.fall);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 20000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 / R9: reset state
        step(IDLE, "R1", 1'b1);
        @(posedge clk); #1;
        chk(dout_lo === 1'b0, "R9 reset level", dout_lo, 1'b0);
        step(IDLE, "R1", 1'b1);
        step(IDLE, "R1", 1'b1);
        step(1'b1, "R1", 1'b0);
        @(posedge clk); #1;
        chk(dout_lo === 1'b0 && rise_lo === 1'b0, "R9 first cycle after release", dout_lo, 1'b0);
        hold(1'b1, 6, "R1");
        // R3 and R8: clean fall
        hold(1'b0, 8, "R3/R8");
        // R4: short high glitches
        for (int w = 1; w < N; w++) begin
            hold(1'b1, w, "R4");
            hold(1'b0, 8, "R4");
        end
        // R5: pulse of exactly N cycles passes
        hold(1'b1, N, "R5");
        hold(1'b0, 10, "R5");
        // R2 and R7: clean rise
        hold(1'b1, 8, "R2/R7");
        // R4: short low glitches
        for (int w = 1; w < N; w++) begin
            hold(1'b0, w, "R4");
            hold(1'b1, 8, "R4");
        end
        // R6: disagreeing samples hold the output
        for (int i = 0; i < 6; i++) begin
            hold(1'b0, 1, "R6");
            hold(1'b1, 1, "R6");
        end
        hold(1'b0, 3, "R6");
        hold(1'b1, 2, "R6");
        hold(1'b0, 3, "R6");
        hold(1'b1, 8, "R6");
        // R1: reset applied while the output is low
        hold(1'b0, 8, "R3/R8");
        step(1'b0, "R1", 1'b1);
        step(1'b0, "R1", 1'b1);
        hold(1'b1, 6, "R1");
        @(negedge clk);
        @(negedge clk);
        #1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule